// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block produces all of the refresh traffic that a 2048-row DRAM module needs, and the power-up traffic before it. After a synchronous reset it stays off the memory bus for a programmable pause of at least 200 µs. It then runs eight CAS-before-RAS refresh cycles as the initialisation sequence and raises `init_done`. From then on it issues one CAS-before-RAS refresh for each tick of a free-running interval timer. The default tick period is 15.6 µs at 250 MHz, so all 2048 rows are covered inside 32 ms.

The block shares the strobes with an access controller through a request/grant handshake. It raises `bus_req` whenever it has refresh work pending. When it sees `bus_gnt` while idle, it takes the bus (`bus_own`) for one complete refresh cycle. Both row strobes and all four column strobes fall and rise together, so every device on the module refreshes at the same moment. Write-enable is held high for the whole time. Refreshes that fall due while the grant is withheld are remembered, up to a cap, and are then issued back to back.

Top module: `dref_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, every row and column strobe is high (inactive), `bus_req`, `bus_own` and `init_done` are low, and `we_n` is high.
- R2: For the first PAUSE_CYCLES clock edges after reset, `bus_req` and `bus_own` stay low even if `bus_gnt` is high. `bus_req` first reads high after exactly PAUSE_CYCLES edges.
- R3: After the pause, exactly INIT_CYCLES (8) refresh cycles run before `init_done` rises. `init_done` rises on the clock edge right after the last precharge cycle of the eighth refresh, and then stays high until reset.
- R4: In every refresh, the column strobes fall LEAD_CYCLES cycles before the row strobes fall. The column strobes stay low for the first HOLD_CYCLES cycles of the row-low phase and then rise.
- R5: In every refresh, the row strobes stay low for exactly RAS_CYCLES cycles. A precharge of PRE_CYCLES cycles follows, with all strobes high, before `bus_own` drops. Column strobes never fall while the row strobes are high inside a precharge.
- R6: `we_n` is high on every cycle.
- R7: The two row strobes are always equal, and the four column strobes are always equal.
- R8: A free-running timer ticks once every INTERVAL_CYCLES edges, counted from reset. Each tick that comes after `init_done` adds one owed refresh. Ticks that come before `init_done` are discarded.
- R9: At most MAX_OWED (8) refreshes are owed at once. A tick that comes while the count is at the cap is lost.
- R10: `bus_req` is high while initialisation refreshes remain or any refresh is owed. A refresh starts on the edge at which `bus_req` and `bus_gnt` are both high and the block is idle, so at least one idle cycle separates two refreshes. `bus_gnt` has no effect while a refresh is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_gnt | input | 1 | Grant from the access controller |
| bus_req | output | 1 | Request for the memory bus |
| bus_own | output | 1 | High while the block drives the strobes |
| ras_n | output | RAS_LINES | Row strobes, active low |
| cas_n | output | CAS_LINES | Column strobes, active low |
| we_n | output | 1 | Write-enable, held high |
| init_done | output | 1 | Power-up sequence complete |

## Verification
A refresh starts on the edge at which grant is sampled while idle. Its first pattern (columns low, rows high) shows on the following cycle, and every later phase boundary follows after a fixed number of edges. `bus_req` reacts one edge after a tick or after the last precharge cycle. `init_done` rises one edge after the eighth precharge ends. The bench keeps a behavioural model that queues the whole strobe pattern of a refresh at its start edge, and it counts ticks and the pause on integers. It compares every output at the falling clock edge, halfway between the edges at which the design and the model update. The pause length, the number of initialisation refreshes and the size of a saturated burst are also checked as totals.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_ROW   = 2'd2,
        PH_PRECH = 2'd3
    } phase_t;

    typedef struct packed {
        logic row_n;
        logic col_n;
        logic own;
        logic done;
    } strobe_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dref_interval.sv
module dref_interval #(
    parameter int INTERVAL_CYCLES = 3900
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import dref_pkg::*;

    localparam int TW = bits_for(INTERVAL_CYCLES);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYCLES - 1);

    logic [TW-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst)               tcnt <= '0;
        else if (tcnt == LAST) tcnt <= '0;
        else                   tcnt <= tcnt + 1'b1;
    end

    assign tick = (tcnt == LAST);

endmodule

// File: rtl/dref_debt.sv
module dref_debt #(
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic pending
);
    import dref_pkg::*;

    localparam int OW = bits_for(MAX_OWED + 1);
    localparam logic [OW-1:0] CAP = OW'(MAX_OWED);

    logic [OW-1:0] owed;

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else if (inc && !dec) begin
            if (owed != CAP) owed <= owed + 1'b1;
        end else if (dec && !inc) begin
            if (owed != '0) owed <= owed - 1'b1;
        end
    end

    assign pending = (owed != '0);

    // R9: a tick at the cap leaves the count at the cap
    p_owed_cap_r9: assert property (@(posedge clk) disable iff (rst)
        (owed == CAP && inc && !dec) |=> (owed == CAP));

    // R9: the count never passes the cap
    p_owed_bound_r9: assert property (@(posedge clk) disable iff (rst)
        owed <= CAP);

endmodule

// File: rtl/dref_cbr_engine.sv
module dref_cbr_engine #(
    parameter int LEAD_CYCLES = 2,
    parameter int HOLD_CYCLES = 3,
    parameter int RAS_CYCLES  = 15,
    parameter int PRE_CYCLES  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output dref_pkg::strobe_t  strobe
);
    import dref_pkg::*;

    localparam int CW = bits_for(max3(LEAD_CYCLES, RAS_CYCLES, PRE_CYCLES));
    localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_CYCLES - 1);
    localparam logic [CW-1:0] ROW_LAST  = CW'(RAS_CYCLES - 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_CYCLES - 1);
    localparam logic [CW-1:0] COL_RISE  = CW'(RAS_CYCLES - HOLD_CYCLES);

    phase_t        phase;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_LEAD;
                    cnt   <= LEAD_LAST;
                end
                PH_LEAD: if (cnt == '0) begin
                    phase <= PH_ROW;
                    cnt   <= ROW_LAST;
                end else cnt <= cnt - 1'b1;
                PH_ROW: if (cnt == '0) begin
                    phase <= PH_PRECH;
                    cnt   <= PRE_LAST;
                end else cnt <= cnt - 1'b1;
                PH_PRECH: if (cnt == '0) begin
                    phase <= PH_IDLE;
                end else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        strobe.row_n = (phase != PH_ROW);
        strobe.col_n = !((phase == PH_LEAD) || (phase == PH_ROW && cnt >= COL_RISE));
        strobe.own   = (phase != PH_IDLE);
        strobe.done  = (phase == PH_PRECH) && (cnt == '0);
    end

    // R4: the row strobe only falls after a cycle with the column strobe low
    p_cas_first_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe.row_n) |-> (!strobe.col_n && $past(!strobe.col_n)));

    // R5: precharge starts with the column strobe high
    p_prech_cas_high_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe.row_n) |-> strobe.col_n);

    // R10: a cycle begins only from idle
    p_start_from_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe.own) |-> (!strobe.col_n && strobe.row_n));

endmodule

// File: rtl/dref_sequencer.sv
module dref_sequencer #(
    parameter int PAUSE_CYCLES    = 50000,
    parameter int INIT_CYCLES     = 8,
    parameter int INTERVAL_CYCLES = 3900,
    parameter int MAX_OWED        = 8,
    parameter int LEAD_CYCLES     = 2,
    parameter int HOLD_CYCLES     = 3,
    parameter int RAS_CYCLES      = 15,
    parameter int PRE_CYCLES      = 10,
    parameter int RAS_LINES       = 2,
    parameter int CAS_LINES       = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_gnt,
    output logic                 bus_req,
    output logic                 bus_own,
    output logic [RAS_LINES-1:0] ras_n,
    output logic [CAS_LINES-1:0] cas_n,
    output logic                 we_n,
    output logic                 init_done
);
    import dref_pkg::*;

    localparam int PW = bits_for(PAUSE_CYCLES);
    localparam int IW = bits_for(INIT_CYCLES + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYCLES - 1);
    localparam logic [IW-1:0] INIT_LOAD  = IW'(INIT_CYCLES);

    logic [PW-1:0] pause_cnt;
    logic          pause_done;
    logic [IW-1:0] init_left;
    logic          tick;
    logic          owed_any;
    logic          start;
    strobe_t       strobe;

    // power-up pause
    always_ff @(posedge clk) begin
        if (rst) begin
            pause_cnt  <= '0;
            pause_done <= 1'b0;
        end else if (!pause_done) begin
            if (pause_cnt == PAUSE_LAST) pause_done <= 1'b1;
            else                         pause_cnt  <= pause_cnt + 1'b1;
        end
    end

    // initialisation refresh count
    always_ff @(posedge clk) begin
        if (rst) begin
            init_left <= INIT_LOAD;
            init_done <= 1'b0;
        end else if (strobe.done && !init_done) begin
            init_left <= init_left - 1'b1;
            if (init_left == IW'(1)) init_done <= 1'b1;
        end
    end

    dref_interval #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_interval (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dref_debt #(.MAX_OWED(MAX_OWED)) u_debt (
        .clk     (clk),
        .rst     (rst),
        .inc     (tick && init_done),
        .dec     (strobe.done && init_done),
        .pending (owed_any)
    );

    assign bus_req = pause_done && ((init_left != '0) || owed_any);
    assign start   = bus_req && bus_gnt && !strobe.own;

    dref_cbr_engine #(
        .LEAD_CYCLES (LEAD_CYCLES),
        .HOLD_CYCLES (HOLD_CYCLES),
        .RAS_CYCLES  (RAS_CYCLES),
        .PRE_CYCLES  (PRE_CYCLES)
    ) u_engine (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .strobe (strobe)
    );

    genvar gi;
    generate
        for (gi = 0; gi < RAS_LINES; gi++) begin : g_row
            assign ras_n[gi] = strobe.row_n;
        end
        for (gi = 0; gi < CAS_LINES; gi++) begin : g_col
            assign cas_n[gi] = strobe.col_n;
        end
    endgenerate

    assign bus_own = strobe.own;
    assign we_n    = 1'b1;

    // R2: nothing is requested during the pause
    p_quiet_pause_r2: assert property (@(posedge clk) disable iff (rst)
        !pause_done |-> (!bus_req && !bus_own));

    // R10: the bus is only held while work is requested
    p_own_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        bus_own |-> bus_req);

    // R3: init-done rises only after a completed refresh
    p_init_after_done_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(strobe.done));

    // R3: init-done stays high once set
    p_init_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

endmodule

// File: tb/dref_sequencer_test.sv
module dref_sequencer_test;

    localparam int PAUSE = 40;
    localparam int NINIT = 8;
    localparam int INTV  = 60;
    localparam int CAP   = 8;
    localparam int LEAD  = 2;
    localparam int HOLD  = 3;
    localparam int RASC  = 15;
    localparam int PREC  = 10;
    localparam int LEN   = LEAD + RASC + PREC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_gnt = 1'b0;
    logic       bus_req, bus_own, we_n, init_done;
    logic [1:0] ras_n;
    logic [3:0] cas_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    dref_sequencer #(
        .PAUSE_CYCLES(PAUSE), .INIT_CYCLES(NINIT), .INTERVAL_CYCLES(INTV),
        .MAX_OWED(CAP), .LEAD_CYCLES(LEAD), .HOLD_CYCLES(HOLD),
        .RAS_CYCLES(RASC), .PRE_CYCLES(PREC), .RAS_LINES(2), .CAS_LINES(4)
    ) uut (
        .clk(clk), .rst(rst), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .init_done(init_done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model: queue of {ras_low, cas_low} per cycle of a refresh
    int m_t, m_owed, m_init_left, m_ticks;
    bit m_pause_done, m_init_done, m_max_seen;
    int pat[$];

    function automatic int m_req();
        return (m_pause_done && (m_init_left > 0 || m_owed > 0)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_t = 0; m_owed = 0; m_init_left = NINIT; m_ticks = 0;
            m_pause_done = 0; m_init_done = 0;
            pat.delete();
        end else begin
            bit done, tk, st;
            done = (pat.size() == 1);
            tk   = ((m_t % INTV) == INTV - 1);
            st   = (m_req() == 1) && bus_gnt && (pat.size() == 0);
            if (tk) m_ticks++;
            if (pat.size() > 0) void'(pat.pop_front());
            if (st) begin
                for (int i = 0; i < LEN; i++) begin
                    int rl, cl;
                    rl = (i >= LEAD && i < LEAD + RASC) ? 1 : 0;
                    cl = (i < LEAD + HOLD) ? 1 : 0;
                    pat.push_back(rl * 2 + cl);
                end
            end
            if (m_init_done) begin
                if (tk && !done && m_owed < CAP) m_owed++;
                else if (done && !tk && m_owed > 0) m_owed--;
            end else if (done) begin
                m_init_left--;
                if (m_init_left == 0) m_init_done = 1;
            end
            if (m_owed == CAP) m_max_seen = 1;
            if (m_t == PAUSE - 1) m_pause_done = 1;
            m_t++;
        end
    end

    // per-cycle comparison at the falling edge
    int  cyc = 0;
    int  first_req = -1;
    int  init_falls = 0;
    bit  ras_prev = 1'b1;
    bit  cmp_on = 1'b0;
    int  burst_falls = 0;
    bit  burst_on = 1'b0;

    always @(posedge clk) if (!rst) cyc++;

    always @(negedge clk) begin
        if (cmp_on) begin
            int exp_rl, exp_cl;
            exp_rl = (pat.size() > 0) ? pat[0] / 2 : 0;
            exp_cl = (pat.size() > 0) ? pat[0] % 2 : 0;
            check("R4", "cas_n", int'(cas_n[0]), 1 - exp_cl);
            check("R5", "ras_n", int'(ras_n[0]), 1 - exp_rl);
            check("R5", "bus_own", int'(bus_own), (pat.size() > 0) ? 1 : 0);
            check("R10", "bus_req", int'(bus_req), m_req());
            check("R3", "init_done", int'(init_done), int'(m_init_done));
            check("R6", "we_n", int'(we_n), 1);
            check("R7", "row lines equal", int'(ras_n[1]), int'(ras_n[0]));
            check("R7", "col lines equal", int'(cas_n == {4{cas_n[0]}}), 1);
            if (bus_req && first_req < 0) first_req = cyc;
            if (ras_prev && !ras_n[0]) begin
                if (!init_done) init_falls++;
                if (burst_on) burst_falls++;
            end
            ras_prev = ras_n[0];
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int tk0, lfsr;
        repeat (3) @(negedge clk);
        // R1: state under reset
        check("R1", "ras_n in reset", int'(ras_n), 3);
        check("R1", "cas_n in reset", int'(cas_n), 15);
        check("R1", "bus_req in reset", int'(bus_req), 0);
        check("R1", "init_done in reset", int'(init_done), 0);
        rst = 1'b0;
        bus_gnt = 1'b1;            // R2: grant during the pause has no effect
        cmp_on = 1'b1;
        @(negedge clk);
        check("R1", "bus_own after reset", int'(bus_own), 0);
        wait (init_done);
        @(negedge clk);
        check("R2", "first request edge", first_req, PAUSE);
        check("R3", "init refresh count", init_falls, NINIT);
        // normal periodic service
        repeat (6 * INTV) @(negedge clk);
        // R9: withhold grant long enough to overflow the owed count
        bus_gnt = 1'b0;
        repeat (12 * INTV) @(negedge clk);
        check("R9", "owed cap reached", int'(m_max_seen), 1);
        tk0 = m_ticks;
        burst_on = 1'b1;
        bus_gnt = 1'b1;
        @(negedge clk);
        while (bus_req) @(negedge clk);
        burst_on = 1'b0;
        // R8, R9: burst drains the cap plus ticks seen while draining
        check("R9", "burst refresh count", burst_falls, CAP + (m_ticks - tk0));
        // R10: grant toggling, including drops inside a refresh
        lfsr = 16'hACE1;
        for (int k = 0; k < 1500; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]} & 16'hFFFF;
            bus_gnt = lfsr[0] & lfsr[3];
            @(negedge clk);
        end
        bus_gnt = 1'b0;
        @(negedge clk);
        check("R8", "owed refreshes pending with grant low", int'(bus_req), m_req());
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule